// File: doc/BRIEF.md
# Fetch Target Queue

The fetch target queue keeps one slot for every fetch packet the front end hands to the rest of the pipeline. Each slot stores the packet's starting PC together with the branch-prediction metadata produced for that address. When a packet is accepted, the queue returns a pointer that travels with the packet's micro-ops. Execution-stage logic can then look up the PC and prediction data by index at any time while the slot is live.

Slots are freed strictly in order from the head, one per cycle, when the commit stage reports a committed instruction. When a branch resolves against its prediction, the back end sends a redirect carrying the pointer of the offending packet. The queue then drops every younger slot by moving its tail to just past that pointer. In the same cycle it overwrites the metadata of the redirected slot with the resolved outcome.

The queue depth must be a power of two and at least 2. Pointers are one bit wider than the slot index. The extra top bit flips on every lap around the ring, which lets a full queue be told apart from an empty one.

Top module: `fetch_target_queue`

## Requirements
- R1: After reset the queue is empty: `enq_ready` is 1, `enq_ptr` and `head_ptr` are 0, and every slot reads back PC 0 and metadata 0.
- R2: An enqueue happens when `enq_valid` and `enq_ready` are both 1. It writes the slot at index `enq_ptr[IDX_W-1:0]` and then advances `enq_ptr` by one, modulo 2*DEPTH, so the top bit flips each time the index wraps from DEPTH-1 to 0.
- R3: Each read port r returns, in the same cycle, the PC and metadata stored in the slot selected by its index field. That field is `rd_idx[r*IDX_W +: IDX_W]`, and the results appear in `rd_pc[r*PC_W +: PC_W]` and `rd_meta[r*META_W +: META_W]`.
- R4: When DEPTH slots are live, `enq_ready` is 0 and `enq_valid` is ignored: `enq_ptr` and all slot contents stay unchanged.
- R5: A commit (`commit_valid`) on a non-empty queue advances `head_ptr` by one, modulo 2*DEPTH. A commit on an empty queue is ignored and `head_ptr` stays unchanged.
- R6: A commit and an enqueue in the same cycle on a queue that is not full both take effect.
- R7: A redirect (`redir_valid`) sets `enq_ptr` to `redir_ptr + 1`, modulo 2*DEPTH, on the next cycle. This discards all younger slots.
- R8: A redirect replaces the metadata of the slot at `redir_ptr[IDX_W-1:0]` with `redir_meta`. That slot's PC is left unchanged.
- R9: A redirect takes priority over an enqueue: `enq_ready` is 0 while `redir_valid` is 1, and no slot receives the offered packet.
- R10: A redirect and a commit in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Front end offers a fetch packet |
| enq_pc | input | PC_W | Fetch-packet PC |
| enq_meta | input | META_W | Prediction metadata for the packet |
| enq_ready | output | 1 | Queue can accept the packet this cycle |
| enq_ptr | output | IDX_W+1 | Pointer assigned to the offered packet (the tail) |
| commit_valid | input | 1 | Free the oldest slot |
| head_ptr | output | IDX_W+1 | Pointer of the oldest live slot |
| redir_valid | input | 1 | Misprediction redirect |
| redir_ptr | input | IDX_W+1 | Pointer of the mispredicted packet |
| redir_meta | input | META_W | Resolved prediction metadata |
| rd_idx | input | NUM_RD*IDX_W | Slot index per read port |
| rd_pc | output | NUM_RD*PC_W | PC per read port |
| rd_meta | output | NUM_RD*META_W | Metadata per read port |

## Verification
Commit moves the head while enqueue or redirect moves the tail, so a commit can land in the same cycle as either one. A redirect can also arrive together with an offered enqueue. The bench provokes each pairing directly, including a commit offered while the queue is full and one offered while it is empty. A long pseudo-random sweep on a four-slot queue then mixes all three inputs freely. After every cycle the bench judges both pointers, the ready flag and the complete contents read back through both ports, comparing them against a pointer-arithmetic model.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

    typedef enum logic [1:0] {
        TAIL_HOLD = 2'd0,
        TAIL_PUSH = 2'd1,
        TAIL_ROLL = 2'd2
    } tail_op_e;

    function automatic int unsigned idx_bits(input int unsigned depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/ftq_ptr_ctrl.sv
module ftq_ptr_ctrl
    import ftq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = idx_bits(DEPTH),
    localparam int unsigned PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic             commit_valid,
    input  logic             redir_valid,
    input  logic [PTR_W-1:0] redir_ptr,
    output logic             enq_ready,
    output logic [PTR_W-1:0] head_ptr,
    output logic [PTR_W-1:0] tail_ptr,
    output tail_op_e         tail_op
);

    localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);
    localparam logic [PTR_W:0]   DEPTH_W = (PTR_W + 1)'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } ptr_state_t;

    ptr_state_t       st_d, st_q;
    logic             full, empty, commit_fire;
    logic [PTR_W-1:0] occ;

    always_comb begin
        empty       = (st_q.head == st_q.tail);
        full        = (st_q.head[IDX_W-1:0] == st_q.tail[IDX_W-1:0]) &&
                      (st_q.head[IDX_W] != st_q.tail[IDX_W]);
        occ         = st_q.tail - st_q.head;
        enq_ready   = !full && !redir_valid;
        commit_fire = commit_valid && !empty;
        st_d        = st_q;
        tail_op     = TAIL_HOLD;
        if (redir_valid) begin
            st_d.tail = redir_ptr + ONE;
            tail_op   = TAIL_ROLL;
        end else if (enq_valid && enq_ready) begin
            st_d.tail = st_q.tail + ONE;
            tail_op   = TAIL_PUSH;
        end
        if (commit_fire) begin
            st_d.head = st_q.head + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_ptr = st_q.head;
    assign tail_ptr = st_q.tail;

    assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, occ} <= DEPTH_W);

    assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && full && !redir_valid) |=> $stable(st_q.tail));

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_op == TAIL_PUSH) |=> (st_q.tail == $past(st_q.tail) + ONE));

    assert_empty_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && empty) |=> $stable(st_q.head));

    assert_roll_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (st_q.tail == $past(redir_ptr) + ONE));

endmodule

// File: rtl/ftq_entry.sv
module ftq_entry #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned META_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [PC_W-1:0]   push_pc,
    input  logic [META_W-1:0] push_meta,
    input  logic              fix_en,
    input  logic [META_W-1:0] fix_meta,
    output logic [PC_W-1:0]   pc_q,
    output logic [META_W-1:0] meta_q
);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [META_W-1:0] meta;
    } slot_t;

    slot_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (push_en) begin
            ent_d.pc   = push_pc;
            ent_d.meta = push_meta;
        end
        if (fix_en) begin
            ent_d.meta = fix_meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign pc_q   = ent_q.pc;
    assign meta_q = ent_q.meta;

    assert_fix_meta_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |=> (meta_q == $past(fix_meta)));

    assert_fix_keeps_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_en && !push_en) |=> $stable(pc_q));

endmodule

// File: rtl/ftq_read_port.sv
module ftq_read_port #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 48,
    parameter int unsigned IDX_W = 3
) (
    input  logic [W-1:0]     slots [DEPTH],
    input  logic [IDX_W-1:0] sel,
    output logic [W-1:0]     dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == IDX_W'(i)) dout = slots[i];
        end
    end

endmodule

// File: rtl/fetch_target_queue.sv
module fetch_target_queue
    import ftq_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PC_W   = 32,
    parameter int unsigned META_W = 16,
    parameter int unsigned NUM_RD = 2,
    localparam int unsigned IDX_W = idx_bits(DEPTH),
    localparam int unsigned PTR_W = IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enq_valid,
    input  logic [PC_W-1:0]          enq_pc,
    input  logic [META_W-1:0]        enq_meta,
    output logic                     enq_ready,
    output logic [PTR_W-1:0]         enq_ptr,
    input  logic                     commit_valid,
    output logic [PTR_W-1:0]         head_ptr,
    input  logic                     redir_valid,
    input  logic [PTR_W-1:0]         redir_ptr,
    input  logic [META_W-1:0]        redir_meta,
    input  logic [NUM_RD*IDX_W-1:0]  rd_idx,
    output logic [NUM_RD*PC_W-1:0]   rd_pc,
    output logic [NUM_RD*META_W-1:0] rd_meta
);

    localparam int unsigned SLOT_W = PC_W + META_W;

    tail_op_e         tail_op;
    logic [PTR_W-1:0] tail_ptr;
    logic [SLOT_W-1:0] slots [DEPTH];

    ftq_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enq_valid    (enq_valid),
        .commit_valid (commit_valid),
        .redir_valid  (redir_valid),
        .redir_ptr    (redir_ptr),
        .enq_ready    (enq_ready),
        .head_ptr     (head_ptr),
        .tail_ptr     (tail_ptr),
        .tail_op      (tail_op)
    );

    assign enq_ptr = tail_ptr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic              push_en, fix_en;
        logic [PC_W-1:0]   pc_q;
        logic [META_W-1:0] meta_q;

        assign push_en = (tail_op == TAIL_PUSH) && (tail_ptr[IDX_W-1:0] == IDX_W'(i));
        assign fix_en  = redir_valid && (redir_ptr[IDX_W-1:0] == IDX_W'(i));

        ftq_entry #(.PC_W(PC_W), .META_W(META_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_en   (push_en),
            .push_pc   (enq_pc),
            .push_meta (enq_meta),
            .fix_en    (fix_en),
            .fix_meta  (redir_meta),
            .pc_q      (pc_q),
            .meta_q    (meta_q)
        );

        assign slots[i] = {pc_q, meta_q};
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        logic [SLOT_W-1:0] dout;

        ftq_read_port #(.DEPTH(DEPTH), .W(SLOT_W), .IDX_W(IDX_W)) u_port (
            .slots (slots),
            .sel   (rd_idx[r*IDX_W +: IDX_W]),
            .dout  (dout)
        );

        assign rd_pc[r*PC_W +: PC_W]       = dout[SLOT_W-1:META_W];
        assign rd_meta[r*META_W +: META_W] = dout[META_W-1:0];
    end

endmodule

// File: tb/fetch_target_queue_test.sv
module fetch_target_queue_test;

    localparam int D     = 4;
    localparam int IW    = 2;
    localparam int PW    = 3;
    localparam int PCW   = 16;
    localparam int MW    = 8;
    localparam int NR    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic [PCW-1:0] enq_pc = '0;
    logic [MW-1:0] enq_meta = '0;
    logic enq_ready;
    logic [PW-1:0] enq_ptr;
    logic commit_valid = 1'b0;
    logic [PW-1:0] head_ptr;
    logic redir_valid = 1'b0;
    logic [PW-1:0] redir_ptr = '0;
    logic [MW-1:0] redir_meta = '0;
    logic [NR*IW-1:0] rd_idx = '0;
    logic [NR*PCW-1:0] rd_pc;
    logic [NR*MW-1:0] rd_meta;

    always #10 clk = ~clk;

    fetch_target_queue #(.DEPTH(D), .PC_W(PCW), .META_W(MW), .NUM_RD(NR)) uut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_pc(enq_pc), .enq_meta(enq_meta),
        .enq_ready(enq_ready), .enq_ptr(enq_ptr),
        .commit_valid(commit_valid), .head_ptr(head_ptr),
        .redir_valid(redir_valid), .redir_ptr(redir_ptr), .redir_meta(redir_meta),
        .rd_idx(rd_idx), .rd_pc(rd_pc), .rd_meta(rd_meta)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int hm = 0;
    int tm = 0;
    int mpc [D];
    int mmeta [D];
    string tail_tag = "R1";
    string head_tag = "R1";
    string rdy_tag  = "R1";
    string rd_tag   = "R1";
    logic [31:0] rs = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return int'(rs[30:0]);
    endfunction

    function automatic int occ();
        return (tm - hm + 2 * D) % (2 * D);
    endfunction

    task automatic step(input bit ev, input int epc, input int emeta, input bit cv,
                        input bit rv, input int rp, input int rm);
        bit exp_rdy, efire, cfire;
        enq_valid    = ev;
        enq_pc       = PCW'(epc);
        enq_meta     = MW'(emeta);
        commit_valid = cv;
        redir_valid  = rv;
        redir_ptr    = PW'(rp);
        redir_meta   = MW'(rm);
        #1;
        exp_rdy = (occ() < D) && !rv;
        chk(enq_ready == exp_rdy, rv ? "R9" : rdy_tag, "enq_ready", int'(enq_ready), int'(exp_rdy));
        chk(int'(enq_ptr) == tm, tail_tag, "enq_ptr", int'(enq_ptr), tm);
        chk(int'(head_ptr) == hm, head_tag, "head_ptr", int'(head_ptr), hm);
        for (int k = 0; k < D; k++) begin
            rd_idx = {IW'(D - 1 - k), IW'(k)};
            #1;
            chk(int'(rd_pc[PCW-1:0]) == mpc[k], rd_tag, "rd_pc port0", int'(rd_pc[PCW-1:0]), mpc[k]);
            chk(int'(rd_meta[MW-1:0]) == mmeta[k], rd_tag, "rd_meta port0", int'(rd_meta[MW-1:0]), mmeta[k]);
            chk(int'(rd_pc[2*PCW-1:PCW]) == mpc[D-1-k], rd_tag, "rd_pc port1", int'(rd_pc[2*PCW-1:PCW]), mpc[D-1-k]);
            chk(int'(rd_meta[2*MW-1:MW]) == mmeta[D-1-k], rd_tag, "rd_meta port1", int'(rd_meta[2*MW-1:MW]), mmeta[D-1-k]);
        end
        @(posedge clk);
        efire = ev && exp_rdy;
        cfire = cv && (occ() > 0);
        if (rv && ev)            tail_tag = "R9";
        else if (rv)             tail_tag = "R7";
        else if (efire && cfire) tail_tag = "R6";
        else if (ev && !efire)   tail_tag = "R4";
        else                     tail_tag = "R2";
        if (rv && cfire)         head_tag = "R10";
        else if (efire && cfire) head_tag = "R6";
        else                     head_tag = "R5";
        rdy_tag = "R4";
        rd_tag  = rv ? "R8" : (ev && !efire) ? "R4" : "R3";
        if (rv) begin
            mmeta[rp % D] = rm % 256;
            tm = (rp + 1) % (2 * D);
        end else if (efire) begin
            mpc[tm % D]   = epc % 65536;
            mmeta[tm % D] = emeta % 256;
            tm = (tm + 1) % (2 * D);
        end
        if (cfire) hm = (hm + 1) % (2 * D);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) begin
            mpc[i] = 0;
            mmeta[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, then R2 fill and R4 overflow attempt
        step(0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < D + 2; i++) step(1, 16'h100 + i, 8'h10 + i, 0, 0, 0, 0);
        // R4/R5: commit while full with enqueue offered
        step(1, 16'hBAD0, 8'hEE, 1, 0, 0, 0);
        // R6: commit plus enqueue with room
        step(1, 16'h200, 8'h21, 1, 0, 0, 0);
        step(1, 16'h201, 8'h22, 1, 0, 0, 0);
        // R5: drain then commit on empty
        for (int i = 0; i < D + 2; i++) step(0, 0, 0, 1, 0, 0, 0);
        // R7/R8/R9/R10: redirect mid-queue with enqueue and commit together
        for (int i = 0; i < 3; i++) step(1, 16'h300 + i, 8'h30 + i, 0, 0, 0, 0);
        step(1, 16'hDEAD, 8'hAA, 1, 1, (hm + 1) % (2 * D), 8'h5C);
        step(0, 0, 0, 0, 0, 0, 0);
        // redirect at the newest entry across the wrap point
        step(0, 0, 0, 0, 1, (tm + 2 * D - 1) % (2 * D), 8'h77);
        step(0, 0, 0, 0, 0, 0, 0);
        // near-exhaustive mixed sweep
        for (int n = 0; n < 4000; n++) begin
            int r, o;
            bit ev, cv, rv;
            r  = rnd();
            o  = occ();
            ev = (r % 10) < 6;
            cv = ((r / 10) % 10) < 4;
            rv = (o > 0) && (((r / 100) % 10) == 0);
            step(ev, rnd() % 65536, rnd() % 256, cv, rv,
                 (o > 0) ? (hm + (r / 1000) % o) % (2 * D) : 0, rnd() % 256);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule